// File: doc/BRIEF.md
# I2C SCL Clock Generator with Prescaler

This block produces the serial clock for an I2C master. A programmable prescaler divides the system clock down to a module clock. Two phase counters then time the low and the high half of each SCL period on that module clock. Each half lasts its programmed count plus a fixed offset of a few module clocks. The offset follows the prescaler setting, or a mode input can pin it to one value.

The bus engine holds `run_i` high for as long as it wants clock periods. Every period starts with the low half. A strobe marks each SCL falling edge and each rising edge, so that data shifting can be lined up with them. Taking `en_i` low holds the block in a soft reset. While held there it loads the prescaler value, and that value applies once `en_i` rises again. The low count, the high count and the offset mode are loaded at the start of each SCL period.

Top module: `scl_clkgen`

## Requirements
- R1: While `en_i` is high, `mod_tick_o` pulses for one cycle once every PSC+1 system clocks, where PSC is the loaded prescaler value.
- R2: The SCL low half lasts (LOW+d)·(PSC+1) system clocks and the high half lasts (HIGH+d)·(PSC+1) system clocks. These are measured between the strobes that open the halves.
- R3: With `fixed_ofs_i` low, the offset d is 7 when PSC is 0, 6 when PSC is 1, and 5 when PSC is 2 or more.
- R4: With `fixed_ofs_i` high, d is 6 for every PSC.
- R5: While `high_cnt_i` is 0, no period starts: `scl_o` stays high and no strobe is issued.
- R6: While `en_i` is low, `scl_o` is high and there are no ticks and no strobes. The prescaler value is loaded only while `en_i` is low, so a change to `psc_i` made while enabled has no effect on timing.
- R7: With `run_i` low, `scl_o` idles high. If `run_i` falls during a period, that period still completes, and then `scl_o` stays high with no further falling strobe.
- R8: `fall_o` is a one-cycle pulse in the first cycle in which `scl_o` is low, and `rise_o` is a one-cycle pulse in the first cycle in which `scl_o` is high again. The two never coincide.
- R9: A change to `low_cnt_i`, `high_cnt_i` or `fixed_ofs_i` during a period leaves that period unchanged and applies from the next period.
- R10: After `rst_ni` is released with `en_i` low, `scl_o` is 1 and `mod_tick_o`, `fall_o` and `rise_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; low holds the generator in soft reset |
| run_i | input | 1 | Request for SCL periods from the bus engine |
| fixed_ofs_i | input | 1 | Forces the phase offset to 6 |
| psc_i | input | 16 | Prescaler value; module clock = clk / (PSC+1) |
| low_cnt_i | input | 16 | Low-half count in module clocks, before the offset |
| high_cnt_i | input | 16 | High-half count in module clocks, before the offset; 0 stops the clock |
| scl_o | output | 1 | SCL drive level |
| mod_tick_o | output | 1 | One-cycle module-clock tick |
| fall_o | output | 1 | Strobe at an SCL falling edge |
| rise_o | output | 1 | Strobe at an SCL rising edge |

## Verification
The closing tick of a high half can do two things at once: end the current period and load the counts for the next one. The bench provokes this by rewriting the low count in the middle of a low half. It expects that low half to end on the old count, and the low half after the following falling strobe to use the new count. The bench also drops `run_i` partway through a period. It expects the closing tick of that period to return SCL to idle rather than start another period, so that no falling strobe follows.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_state_e;

  localparam logic [2:0] OFS_PSC0  = 3'd7;
  localparam logic [2:0] OFS_PSC1  = 3'd6;
  localparam logic [2:0] OFS_PSCN  = 3'd5;
  localparam logic [2:0] OFS_FIXED = 3'd6;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] psc_i,
  output logic [W-1:0] psc_o,
  output logic         tick_o
);
  logic [W-1:0] psc_q, pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      pcnt_q <= '0;
    end else if (!en_i) begin
      psc_q  <= psc_i;  // loaded only while held in soft reset
      pcnt_q <= '0;
    end else if (pcnt_q == psc_q) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (pcnt_q == psc_q);
  assign psc_o  = psc_q;

  assert_tick_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_q != '0) |=> !tick_o);
  assert_psc_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(psc_q));
endmodule

// File: rtl/scl_ofs_sel.sv
module scl_ofs_sel #(
  parameter int W = 16
) (
  input  logic         fixed_i,
  input  logic [W-1:0] psc_i,
  output logic [2:0]   d_o
);
  import scl_clkgen_pkg::*;

  always_comb begin
    if (fixed_i)                 d_o = OFS_FIXED;
    else if (psc_i == '0)        d_o = OFS_PSC0;
    else if (psc_i == W'(1))     d_o = OFS_PSC1;
    else                         d_o = OFS_PSCN;
  end

  always_comb begin
    assert_ofs_range_R3: assert (d_o >= 3'd5 && d_o <= 3'd7);
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic [2:0]   d_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         scl_o,
  output logic         fall_o,
  output logic         rise_o
);
  import scl_clkgen_pkg::*;

  localparam int LW = W + 1;

  ph_state_e      state_q;
  logic [LW-1:0]  ph_cnt_q, lim_lo_q, lim_hi_q, cur_lim;
  logic           ph_done, start_ok;
  logic [LW-1:0]  d_ext;

  assign d_ext    = {{(LW-3){1'b0}}, d_i};
  assign cur_lim  = (state_q == PH_LOW) ? lim_lo_q : lim_hi_q;
  assign ph_done  = (ph_cnt_q == cur_lim - 1'b1);
  assign start_ok = run_i && (hi_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_IDLE;
      ph_cnt_q <= '0;
      lim_lo_q <= '0;
      lim_hi_q <= '0;
      scl_o    <= 1'b1;
      fall_o   <= 1'b0;
      rise_o   <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      rise_o <= 1'b0;
      if (!en_i) begin
        state_q  <= PH_IDLE;
        ph_cnt_q <= '0;
        scl_o    <= 1'b1;
      end else if (tick_i) begin
        unique case (state_q)
          PH_LOW: begin
            if (ph_done) begin
              state_q  <= PH_HIGH;
              ph_cnt_q <= '0;
              scl_o    <= 1'b1;
              rise_o   <= 1'b1;
            end else begin
              ph_cnt_q <= ph_cnt_q + 1'b1;
            end
          end
          PH_IDLE, PH_HIGH: begin
            if (state_q == PH_HIGH && !ph_done) begin
              ph_cnt_q <= ph_cnt_q + 1'b1;
            end else if (start_ok) begin
              // period boundary: load counts for the new period
              lim_lo_q <= {1'b0, lo_i} + d_ext;
              lim_hi_q <= {1'b0, hi_i} + d_ext;
              state_q  <= PH_LOW;
              ph_cnt_q <= '0;
              scl_o    <= 1'b0;
              fall_o   <= 1'b1;
            end else begin
              state_q  <= PH_IDLE;
              ph_cnt_q <= '0;
            end
          end
          default: state_q <= PH_IDLE;
        endcase
      end
    end
  end

  assert_fall_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !scl_o);
  assert_rise_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> scl_o);
  assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_o, rise_o}));
  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !fall_o && !rise_o));
  assert_no_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE && hi_i == '0) |=> (state_q == PH_IDLE));
  assert_lim_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LOW) |=> ($stable(lim_lo_q) && $stable(lim_hi_q)));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             fixed_ofs_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             scl_o,
  output logic             mod_tick_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [CNT_W-1:0] psc_q;
  logic [2:0]       d_w;

  scl_prescaler #(.W(CNT_W)) u_psc (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i),
    .psc_i (psc_i), .psc_o (psc_q), .tick_o (mod_tick_o)
  );

  scl_ofs_sel #(.W(CNT_W)) u_ofs (
    .fixed_i (fixed_ofs_i), .psc_i (psc_q), .d_o (d_w)
  );

  scl_phase_fsm #(.W(CNT_W)) u_fsm (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i), .tick_i (mod_tick_o),
    .run_i (run_i), .d_i (d_w), .lo_i (low_cnt_i), .hi_i (high_cnt_i),
    .scl_o (scl_o), .fall_o (fall_o), .rise_o (rise_o)
  );
endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
  logic clk = 0, rst_ni = 0, en = 0, run = 0, fixed = 0;
  logic [15:0] psc = 0, lo = 0, hi = 0;
  logic scl, tick, fall, rise;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  scl_clkgen u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .en_i (en), .run_i (run),
    .fixed_ofs_i (fixed), .psc_i (psc), .low_cnt_i (lo), .high_cnt_i (hi),
    .scl_o (scl), .mod_tick_o (tick), .fall_o (fall), .rise_o (rise)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 = fall, 1 = rise, 2 = tick; n = negedges until seen, -1 on timeout
  task automatic wait_evt(input int which, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((which == 0 && fall) || (which == 1 && rise) || (which == 2 && tick)) return;
      if (n > 5000) begin n = -1; return; end
    end
  endtask

  function automatic int exp_d(input int p, input bit f);
    if (f) return 6;
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic setup(input int p, input bit f, input int l, input int h);
    @(negedge clk);
    en = 0; run = 1; psc = 16'(p); fixed = f; lo = 16'(l); hi = 16'(h);
    repeat (2) @(negedge clk);
    en = 1;
  endtask

  initial begin
    int n, tl, th, seen, d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R10 scl", scl, 1);
    chk("R10 tick", tick, 0);
    chk("R10 strobes", fall | rise, 0);

    // R1: tick spacing
    for (int p = 0; p < 4; p++) begin
      setup(p, 0, 1, 1);
      run = 0;
      wait_evt(2, n);
      wait_evt(2, n);
      chk($sformatf("R1 tick gap psc=%0d", p), n, p + 1);
    end

    // R2/R3/R4: sweep
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 2; f++)
        for (int l = 0; l < 4; l += 3)
          for (int h = 1; h < 5; h += 3) begin
            setup(p, f[0], l, h);
            d = exp_d(p, f[0]);
            wait_evt(0, n);
            wait_evt(1, tl);
            wait_evt(0, th);
            chk($sformatf("R2 R3 R4 low p=%0d f=%0d l=%0d", p, f, l), tl, (l + d) * (p + 1));
            chk($sformatf("R2 R3 R4 high p=%0d f=%0d h=%0d", p, f, h), th, (h + d) * (p + 1));
          end

    // R8: strobe shape
    setup(1, 0, 2, 2);
    wait_evt(0, n);
    chk("R8 scl low at fall", scl, 0);
    @(negedge clk);
    chk("R8 fall one cycle", fall, 0);
    wait_evt(1, n);
    chk("R8 scl high at rise", scl, 1);
    chk("R8 no fall with rise", fall, 0);
    @(negedge clk);
    chk("R8 rise one cycle", rise, 0);

    // R5: high count zero
    setup(0, 0, 2, 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!scl || fall || rise) seen++;
    end
    chk("R5 no clock when high count 0", seen, 0);

    // R6: en low mid-run holds idle
    setup(0, 0, 4, 4);
    wait_evt(0, n);
    en = 0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!scl || fall || rise || tick) seen++;
    end
    chk("R6 held idle while disabled", seen, 0);

    // R6: psc change while enabled ignored
    setup(0, 0, 3, 3);
    wait_evt(0, n);
    psc = 16'd3;
    wait_evt(1, tl);
    wait_evt(0, th);
    wait_evt(1, tl);
    chk("R6 psc write ignored while enabled", tl, 10);

    // R7: run drop completes period then idles
    setup(0, 0, 3, 3);
    wait_evt(0, n);
    run = 0;
    wait_evt(1, tl);
    chk("R7 current low completes", tl, 10);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!scl || fall) seen++;
    end
    chk("R7 idle high after run drop", seen, 0);

    // R9: mid-period change applies next period
    setup(0, 0, 2, 2);
    wait_evt(0, n);
    lo = 16'd10;
    wait_evt(1, tl);
    chk("R9 current low keeps old count", tl, 9);
    wait_evt(0, th);
    chk("R9 current high", th, 9);
    wait_evt(1, tl);
    chk("R9 next low uses new count", tl, 17);
    wait_evt(0, th);
    fixed = 1;
    wait_evt(1, tl);
    chk("R9 mode change waits for next period", tl, 17);
    wait_evt(0, th);
    wait_evt(1, tl);
    chk("R4 R9 forced offset next period", tl, 16);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule